// File: doc/BRIEF.md
# Ternary Pattern Match Engine

This block compares each incoming 20-bit key against sixteen stored ternary rows. Every row has a compare value, a care mask and a 20-bit result word. A key bit matches a row bit when the two are equal or when the mask marks that bit as don't-care. When at least one enabled row matches, the block raises its hit flag and loads that row's result word into an output register. When no row matches, the register keeps its value.

The key is taken either as 20 control bits or as 16 data bits followed by 4 control bits. The output is presented in the same two forms. A new key can be accepted on every clock. Its outcome appears after two registers.

Because the result register holds between hits, the output can be fed back as the next key. Used this way, the rows act as the transitions of a small state machine with up to sixteen arcs. The same mechanism parses fixed- or variable-width bit fields. The rows are loaded through a simple write port that is addressed by row index.

Top module: `tcam_matcher`

## Requirements
- R1: With `key_mode`=0 the key is `in_ctrl[19:0]`, and `in_data` does not affect the match.
- R2: With `key_mode`=1 the key is `{in_data[15:0], in_ctrl[3:0]}`, and `in_ctrl[19:4]` does not affect the match.
- R3: A row matches when `((key ^ value) & care) == 0`. A care bit of 0 is a don't-care and a care bit of 1 demands equality.
- R4: On a match of an enabled row, `out_hit` is 1 and the result register takes that row's stored result word.
- R5: When several enabled rows match, the lowest-numbered row supplies the result.
- R6: When no enabled row matches, or `in_vld` was 0, `out_hit` is 0 and the result register keeps its previous value.
- R7: After reset every row is disabled, `out_hit` is 0 and the result register is 0. A disabled row never matches.
- R8: A key sampled at clock edge k is reflected on the outputs just after edge k+1. Keys may arrive on consecutive cycles.
- R9: With `out_mode`=0, `out_ctrl` carries the whole result and `out_data` is 0. With `out_mode`=1, `out_data` is result[19:4], `out_ctrl[3:0]` is result[3:0] and `out_ctrl[19:4]` is 0.
- R10: A write with `cfg_we`=1 stores `cfg_wdata` into row `cfg_row`. The field is chosen by `cfg_sel`: 0 selects the care mask, 1 the compare value, 2 the result word, and 3 the enable bit, which is taken from `cfg_wdata[0]`.
- R11: Feeding `out_ctrl` back as the next key in mode 0 steps through the stored transitions as a state machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_mode | input | 1 | Key form: 0 = 20 control bits, 1 = 16 data + 4 control |
| out_mode | input | 1 | Output form, same coding as key_mode |
| in_vld | input | 1 | Key present this cycle |
| in_ctrl | input | 20 | Control bits of the key |
| in_data | input | 16 | Data bits of the key |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 4 | Row index to write |
| cfg_sel | input | 2 | Field: 0 care, 1 value, 2 result, 3 enable |
| cfg_wdata | input | 20 | Write data |
| out_hit | output | 1 | Hit flag for the key from two cycles earlier |
| out_ctrl | output | 20 | Result, control form |
| out_data | output | 16 | Result, data form |

## Verification
The key stream is chosen to separate the matching cases. Some keys hit exactly one row, one through an exact mask and one through a partly masked mask. One key satisfies three rows at once, which exposes the priority order. Other keys match only a disabled row or no row at all, which shows that a miss holds the result.

The keys are sent back to back in both key forms. The data-form keys carry junk in the unused control bits, and the control-form keys carry junk on `in_data`. A three-state cycle driven by output feedback, an invalid-but-matching key, and re-disabling a row round out the cases that tell priority, hold and enable apart.

// File: rtl/tcam_matcher.sv
module tcam_matcher #(
  parameter int ROWS = 16,
  parameter int DW   = 16,
  parameter int CW   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     key_mode,
  input  logic                     out_mode,
  input  logic                     in_vld,
  input  logic [DW+CW-1:0]         in_ctrl,
  input  logic [DW-1:0]            in_data,
  input  logic                     cfg_we,
  input  logic [$clog2(ROWS)-1:0]  cfg_row,
  input  logic [1:0]               cfg_sel,
  input  logic [DW+CW-1:0]         cfg_wdata,
  output logic                     out_hit,
  output logic [DW+CW-1:0]         out_ctrl,
  output logic [DW-1:0]            out_data
);
  localparam int KW = DW + CW;
  localparam int IW = $clog2(ROWS);

  logic [KW-1:0] row_care [ROWS];
  logic [KW-1:0] row_val  [ROWS];
  logic [KW-1:0] row_res  [ROWS];
  logic [ROWS-1:0] row_en;

  logic [KW-1:0] key_q, res_q;
  logic          v1_q, hit_q, hit_c;
  logic [IW-1:0] sel_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_en <= '0;
      for (int r = 0; r < ROWS; r++) begin
        row_care[r] <= '0;
        row_val[r]  <= '0;
        row_res[r]  <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: row_care[cfg_row] <= cfg_wdata;
        2'd1: row_val[cfg_row]  <= cfg_wdata;
        2'd2: row_res[cfg_row]  <= cfg_wdata;
        default: row_en[cfg_row] <= cfg_wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      key_q <= '0;
    end else begin
      v1_q  <= in_vld;
      key_q <= key_mode ? {in_data, in_ctrl[CW-1:0]} : in_ctrl;
    end
  end

  always_comb begin
    hit_c = 1'b0;
    sel_c = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (row_en[r] && (((key_q ^ row_val[r]) & row_care[r]) == '0)) begin
        hit_c = 1'b1;
        sel_c = IW'(r);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      res_q <= '0;
    end else begin
      hit_q <= v1_q & hit_c;
      if (v1_q && hit_c) res_q <= row_res[sel_c];
    end
  end

  assign out_hit  = hit_q;
  assign out_ctrl = out_mode ? {{DW{1'b0}}, res_q[CW-1:0]} : res_q;
  assign out_data = out_mode ? res_q[KW-1:CW] : '0;

  p_miss_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hit |-> res_q == $past(res_q));

  p_hit_needs_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> $past(v1_q));

  p_disabled_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en == '0) |=> !out_hit);

  p_hit_from_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> $past(row_en) != '0);
endmodule

// File: tb/tb_tcam_matcher.sv
`timescale 1ns/1ps
module tb_tcam_matcher;
  logic clk = 1'b0, rst_n = 1'b0;
  logic key_mode = 1'b0, out_mode = 1'b0, in_vld = 1'b0;
  logic [19:0] in_ctrl = '0;
  logic [15:0] in_data = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_row = '0;
  logic [1:0] cfg_sel = '0;
  logic [19:0] cfg_wdata = '0;
  logic out_hit;
  logic [19:0] out_ctrl;
  logic [15:0] out_data;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  tcam_matcher dut (.clk(clk), .rst_n(rst_n), .key_mode(key_mode), .out_mode(out_mode),
    .in_vld(in_vld), .in_ctrl(in_ctrl), .in_data(in_data), .cfg_we(cfg_we),
    .cfg_row(cfg_row), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .out_hit(out_hit), .out_ctrl(out_ctrl), .out_data(out_data));

  // {mode, ctrl, data, hit, result}
  localparam logic [57:0] VEC [8] = '{
    {1'b0, 20'h12345, 16'hDEAD, 1'b1, 20'hA0001},
    {1'b0, 20'h12377, 16'hBEEF, 1'b1, 20'hB0002},
    {1'b0, 20'h55555, 16'h0000, 1'b1, 20'hC0003},
    {1'b0, 20'hFFFFF, 16'h1234, 1'b0, 20'hC0003},
    {1'b1, 20'hFFFF5, 16'h1234, 1'b1, 20'hA0001},
    {1'b1, 20'h00007, 16'h1237, 1'b1, 20'hB0002},
    {1'b0, 20'h00000, 16'h5555, 1'b0, 20'hB0002},
    {1'b0, 20'hAAAA5, 16'hFFFF, 1'b1, 20'hC0003}
  };

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] row, input logic [1:0] sel, input logic [19:0] d);
    cfg_we = 1'b1; cfg_row = row; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic row(input logic [3:0] r, input logic [19:0] care, input logic [19:0] val,
                     input logic [19:0] res, input logic en);
    wr(r, 2'd0, care); wr(r, 2'd1, val); wr(r, 2'd2, res); wr(r, 2'd3, {19'd0, en});
  endtask

  task automatic apply(input logic m, input logic [19:0] c, input logic [15:0] d, input logic v);
    key_mode = m; in_ctrl = c; in_data = d; in_vld = v;
    @(posedge clk); #1;
    in_vld = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(out_hit == 1'b0 && out_ctrl == 20'h0, "R7 reset state", {20'h0, out_ctrl}, 40'h0);

    row(4'd0, 20'hFFFFF, 20'h12345, 20'hA0001, 1'b0);
    apply(1'b0, 20'h12345, 16'h0, 1'b1);
    chk(out_hit == 1'b0, "R7 row not yet enabled", {39'd0, out_hit}, 40'd0);
    wr(4'd0, 2'd3, 20'd1);
    row(4'd1, 20'hFFF00, 20'h12300, 20'hB0002, 1'b1);
    row(4'd2, 20'h0000F, 20'h00005, 20'hC0003, 1'b1);
    row(4'd3, 20'hFFFFF, 20'hFFFFF, 20'hD0004, 1'b0);

    // R8: back-to-back keys, output one edge after capture edge
    for (int i = 0; i <= 8; i++) begin
      if (i < 8) begin
        key_mode = VEC[i][57]; in_ctrl = VEC[i][56:37]; in_data = VEC[i][36:21]; in_vld = 1'b1;
      end else in_vld = 1'b0;
      @(posedge clk); #1;
      if (i >= 1) begin
        chk(out_hit == VEC[i-1][20], "R3/R4/R5/R6/R8 hit", {39'd0, out_hit}, {39'd0, VEC[i-1][20]});
        chk(out_ctrl == VEC[i-1][19:0] && out_data == 16'h0, "R1/R2/R9 result",
            {out_data, out_ctrl}, {16'h0, VEC[i-1][19:0]});
      end
    end

    apply(1'b0, 20'h12345, 16'h0, 1'b0);
    chk(out_hit == 1'b0 && out_ctrl == 20'hC0003, "R6 invalid key ignored", {19'd0, out_hit, out_ctrl}, {20'h0, 20'hC0003});

    apply(1'b0, 20'h12345, 16'h0, 1'b1);
    out_mode = 1'b1; #1;
    chk(out_data == 16'hA000 && out_ctrl == 20'h00001, "R9 data form output", {out_data, out_ctrl}, {16'hA000, 20'h00001});
    out_mode = 1'b0;

    wr(4'd0, 2'd3, 20'd0);
    apply(1'b0, 20'h12345, 16'h0, 1'b1);
    chk(out_hit && out_ctrl == 20'hB0002, "R10 R5 row0 disabled, row1 wins", {20'h0, out_ctrl}, {20'h0, 20'hB0002});

    wr(4'd2, 2'd1, 20'h00007);
    apply(1'b0, 20'hAAAA7, 16'h0, 1'b1);
    chk(out_hit && out_ctrl == 20'hC0003, "R10 value rewrite", {20'h0, out_ctrl}, {20'h0, 20'hC0003});

    wr(4'd1, 2'd3, 20'd0); wr(4'd2, 2'd3, 20'd0);
    row(4'd4, 20'hFFFFF, 20'h00001, 20'h00002, 1'b1);
    row(4'd5, 20'hFFFFF, 20'h00002, 20'h00003, 1'b1);
    row(4'd6, 20'hFFFFF, 20'h00003, 20'h00001, 1'b1);
    apply(1'b0, 20'h00001, 16'h0, 1'b1);
    for (int s = 0; s < 6; s++) begin
      logic [19:0] e;
      e = (s % 3 == 0) ? 20'h00002 : (s % 3 == 1) ? 20'h00003 : 20'h00001;
      chk(out_hit && out_ctrl == e, "R11 feedback state step", {20'h0, out_ctrl}, {20'h0, e});
      apply(1'b0, out_ctrl, 16'h0, 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule